// File: doc/BRIEF.md
# Instruction Cycle Timing Controller

This block sequences a 16-bit single-accumulator processor through its instruction cycle. A sequence counter advances one step per clock and is decoded into seven one-hot timing steps. The first three steps are the same for every instruction: the program counter is copied to the address register, the instruction word is read into the instruction register while the program counter advances, and then the instruction is decoded. Bits 14..12 select one of eight operation lines, bit 15 is kept as the indirect flag, and bits 11..0 are loaded into the address register. Every later register transfer belongs to exactly one pair of timing step and operation line. Each instruction ends by returning the counter to step zero.

The controller sends a small set of strobes to a datapath that holds the address register, program counter, data register, accumulator and instruction register, all joined by one shared bus. The block executes the seven memory-reference operations itself. Operation line 7 is passed on at step 3 to an outside register-operation unit (bit 15 clear) or an outside input/output unit (bit 15 set). The counter stays at step 3 until that unit reports completion. Word memory sits outside the block and is read combinationally.

Top module: `instr_cycle_ctrl`

## Requirements
- R1: A synchronous reset sets the program counter, the accumulator and all internal registers to zero, and the timing output shows step 0 (timeStep = 7'b0000001) with memRead and memWrite low.
- R2: timeStep is always one-hot. Outside halt and the step-3 wait it moves up by one step per clock, and it returns to step 0 once an instruction completes.
- R3: Fetch takes steps 0 to 2. memRead is high at step 1 with memAddr equal to the program counter value from step 0, and after step 1 the program counter has grown by one.
- R4: At step 3, when bits 14..12 are not 7 and bit 15 is 1, memRead is high and the address register takes bits 11..0 of the word read. When bit 15 is 0, step 3 performs no transfer and no memory access.
- R5: Operations 0 (AND), 1 (ADD, modulo 2^16) and 2 (load) read M[EA] into the data register at step 4. At step 5 the accumulator takes AC&DR, AC+DR or DR respectively, and the instruction ends.
- R6: Operation 3 (store) drives memWrite at step 4 with memWrData equal to the accumulator and memAddr equal to the effective address, then ends.
- R7: Operation 4 (branch) loads the program counter with the effective address at step 4 and ends.
- R8: Operation 5 (call) writes the zero-extended program counter to M[EA] at step 4 and increments the address register. At step 5 it loads the program counter with EA+1 and ends.
- R9: Operation 6 (increment and skip) reads M[EA] at step 4 and increments the data register at step 5. At step 6 it writes that value back and increments the program counter only if the value is zero, then ends.
- R10: Operation 7 raises regRefEn (bit 15 = 0) or ioEn (bit 15 = 1) at step 3. The step holds at 3 while extDone is low and returns to step 0 on the clock where extDone is high.
- R11: While halt is high, the timing step, program counter and accumulator hold, and memRead, memWrite, regRefEn and ioEn stay low.
- R12: memRead and memWrite are never high together, and memWrite is high only at step 4 or step 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| halt | input | 1 | Freezes the cycle and suppresses all strobes |
| extDone | input | 1 | Completion from the outside register or I/O unit |
| memRdData | input | 16 | Word read from memory at memAddr |
| memAddr | output | 12 | Memory address (address register) |
| memWrData | output | 16 | Write data (shared bus value) |
| memRead | output | 1 | Memory read strobe |
| memWrite | output | 1 | Memory write strobe |
| regRefEn | output | 1 | Starts a register-operation instruction at step 3 |
| ioEn | output | 1 | Starts an input/output instruction at step 3 |
| timeStep | output | 7 | One-hot timing step T0..T6 |
| acOut | output | 16 | Accumulator value |
| pcOut | output | 12 | Program counter value |

## Verification
A sequence counter that skips or repeats a step shows up on timeStep in that same cycle. It also moves the memory strobes by one cycle, so it is caught within one clock. A wrong indirect flag or a wrong operation decode makes memRead or memWrite appear at a step where it does not belong, which is visible at step 3 or 4 of the affected instruction. A bad data or address register value reaches memAddr, memWrData or acOut no more than two steps later, and a bad skip or call target reaches pcOut by the end of that instruction.

// File: rtl/icc_pkg.sv
package icc_pkg;

  typedef enum logic [1:0] {
    ALU_PASS = 2'd0,
    ALU_AND  = 2'd1,
    ALU_ADD  = 2'd2
  } aluOp_e;

  // shared bus source codes
  localparam logic [2:0] SEL_NONE = 3'd0;
  localparam logic [2:0] SEL_AR   = 3'd1;
  localparam logic [2:0] SEL_PC   = 3'd2;
  localparam logic [2:0] SEL_DR   = 3'd3;
  localparam logic [2:0] SEL_AC   = 3'd4;
  localparam logic [2:0] SEL_IR   = 3'd5;
  localparam logic [2:0] SEL_MEM  = 3'd7;

  typedef struct packed {
    logic [2:0] busSel;
    logic       arLd;
    logic       arInc;
    logic       pcLd;
    logic       pcInc;
    logic       drLd;
    logic       drInc;
    logic       acLd;
    logic       irLd;
    logic       memRd;
    logic       memWr;
    aluOp_e     aluOp;
  } strobes_t;

endpackage

// File: rtl/icc_datapath.sv
module icc_datapath
  import icc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12
) (
  input  logic                     clk,
  input  logic                     rst,
  input  strobes_t                 st,
  input  logic [DATA_W-1:0]        memRdData,
  output logic [ADDR_W-1:0]        memAddr,
  output logic [DATA_W-1:0]        memWrData,
  output logic                     memRead,
  output logic                     memWrite,
  output logic [DATA_W-ADDR_W-1:0] irTop,
  output logic                     drZero,
  output logic [DATA_W-1:0]        acOut,
  output logic [ADDR_W-1:0]        pcOut
);
  localparam int PAD = DATA_W - ADDR_W;

  logic [ADDR_W-1:0] arReg, pcReg;
  logic [DATA_W-1:0] drReg, acReg, irReg;
  logic [DATA_W-1:0] bus, aluRes;

  always_comb begin
    case (st.busSel)
      SEL_AR:  bus = {{PAD{1'b0}}, arReg};
      SEL_PC:  bus = {{PAD{1'b0}}, pcReg};
      SEL_DR:  bus = drReg;
      SEL_AC:  bus = acReg;
      SEL_IR:  bus = irReg;
      SEL_MEM: bus = memRdData;
      default: bus = '0;
    endcase
  end

  always_comb begin
    case (st.aluOp)
      ALU_AND: aluRes = acReg & drReg;
      ALU_ADD: aluRes = acReg + drReg;
      default: aluRes = drReg;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      arReg <= '0;
      pcReg <= '0;
      drReg <= '0;
      acReg <= '0;
      irReg <= '0;
    end else begin
      if (st.arLd)       arReg <= bus[ADDR_W-1:0];
      else if (st.arInc) arReg <= arReg + 1'b1;
      if (st.pcLd)       pcReg <= bus[ADDR_W-1:0];
      else if (st.pcInc) pcReg <= pcReg + 1'b1;
      if (st.drLd)       drReg <= bus;
      else if (st.drInc) drReg <= drReg + 1'b1;
      if (st.acLd)       acReg <= aluRes;
      if (st.irLd)       irReg <= bus;
    end
  end

  assign memAddr   = arReg;
  assign memWrData = bus;
  assign memRead   = st.memRd;
  assign memWrite  = st.memWr;
  assign irTop     = irReg[DATA_W-1:ADDR_W];
  assign drZero    = (drReg == '0);
  assign acOut     = acReg;
  assign pcOut     = pcReg;

endmodule

// File: rtl/icc_control.sv
module icc_control
  import icc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12,
  parameter int STEPS  = 7
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     halt,
  input  logic                     extDone,
  input  logic [DATA_W-ADDR_W-1:0] irTop,
  input  logic                     drZero,
  output strobes_t                 st,
  output logic [STEPS-1:0]         timeStep,
  output logic                     regRefEn,
  output logic                     ioEn
);
  localparam int TOP_W  = DATA_W - ADDR_W;
  localparam int OPC_W  = TOP_W - 1;
  localparam int NUM_OP = 1 << OPC_W;
  localparam int SC_W   = $clog2(STEPS);

  logic [SC_W-1:0]   seqCnt;
  logic [OPC_W-1:0]  opcode;
  logic [NUM_OP-1:0] dec;
  logic              iFlag, opSeven, scClr;

  assign opcode  = irTop[OPC_W-1:0];
  assign opSeven = dec[NUM_OP-1];

  for (genvar g = 0; g < NUM_OP; g++) begin : g_opdec
    assign dec[g] = (opcode == OPC_W'(g));
  end

  for (genvar g = 0; g < STEPS; g++) begin : g_tdec
    assign timeStep[g] = (seqCnt == SC_W'(g));
  end

  always_ff @(posedge clk) begin
    if (rst)                       iFlag <= 1'b0;
    else if (timeStep[2] && !halt) iFlag <= irTop[TOP_W-1];
  end

  always_ff @(posedge clk) begin
    if (rst)                          seqCnt <= '0;
    else if (halt)                    seqCnt <= seqCnt;
    else if (scClr)                   seqCnt <= '0;
    else if (timeStep[3] && opSeven)  seqCnt <= seqCnt;
    else                              seqCnt <= seqCnt + 1'b1;
  end

  always_comb begin
    st       = '0;
    st.aluOp = ALU_PASS;
    scClr    = 1'b0;
    if (!halt) begin
      if (timeStep[0]) begin
        st.busSel = SEL_PC;  st.arLd = 1'b1;
      end
      if (timeStep[1]) begin
        st.busSel = SEL_MEM; st.memRd = 1'b1; st.irLd = 1'b1; st.pcInc = 1'b1;
      end
      if (timeStep[2]) begin
        st.busSel = SEL_IR;  st.arLd = 1'b1;
      end
      if (timeStep[3]) begin
        if (!opSeven && iFlag) begin
          st.busSel = SEL_MEM; st.memRd = 1'b1; st.arLd = 1'b1;
        end
        if (opSeven && extDone) scClr = 1'b1;
      end
      if (timeStep[4]) begin
        if (dec[0] || dec[1] || dec[2] || dec[6]) begin
          st.busSel = SEL_MEM; st.memRd = 1'b1; st.drLd = 1'b1;
        end
        if (dec[3]) begin
          st.busSel = SEL_AC; st.memWr = 1'b1; scClr = 1'b1;
        end
        if (dec[4]) begin
          st.busSel = SEL_AR; st.pcLd = 1'b1; scClr = 1'b1;
        end
        if (dec[5]) begin
          st.busSel = SEL_PC; st.memWr = 1'b1; st.arInc = 1'b1;
        end
      end
      if (timeStep[5]) begin
        if (dec[0]) begin st.acLd = 1'b1; st.aluOp = ALU_AND;  scClr = 1'b1; end
        if (dec[1]) begin st.acLd = 1'b1; st.aluOp = ALU_ADD;  scClr = 1'b1; end
        if (dec[2]) begin st.acLd = 1'b1; st.aluOp = ALU_PASS; scClr = 1'b1; end
        if (dec[5]) begin
          st.busSel = SEL_AR; st.pcLd = 1'b1; scClr = 1'b1;
        end
        if (dec[6]) st.drInc = 1'b1;
      end
      if (timeStep[6] && dec[6]) begin
        st.busSel = SEL_DR; st.memWr = 1'b1; st.pcInc = drZero; scClr = 1'b1;
      end
    end
  end

  assign regRefEn = !halt && timeStep[3] && opSeven && !iFlag;
  assign ioEn     = !halt && timeStep[3] && opSeven && iFlag;

endmodule

// File: rtl/instr_cycle_ctrl.sv
module instr_cycle_ctrl
  import icc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12,
  parameter int STEPS  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              halt,
  input  logic              extDone,
  input  logic [DATA_W-1:0] memRdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic              memRead,
  output logic              memWrite,
  output logic              regRefEn,
  output logic              ioEn,
  output logic [STEPS-1:0]  timeStep,
  output logic [DATA_W-1:0] acOut,
  output logic [ADDR_W-1:0] pcOut
);
  strobes_t                 st;
  logic [DATA_W-ADDR_W-1:0] irTop;
  logic                     drZero;

  icc_control #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .STEPS(STEPS)) uCtl (
    .clk(clk), .rst(rst), .halt(halt), .extDone(extDone),
    .irTop(irTop), .drZero(drZero), .st(st), .timeStep(timeStep),
    .regRefEn(regRefEn), .ioEn(ioEn)
  );

  icc_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uDp (
    .clk(clk), .rst(rst), .st(st), .memRdData(memRdData),
    .memAddr(memAddr), .memWrData(memWrData), .memRead(memRead),
    .memWrite(memWrite), .irTop(irTop), .drZero(drZero),
    .acOut(acOut), .pcOut(pcOut)
  );

endmodule

// File: rtl/instr_cycle_ctrl_chk.sv
module instr_cycle_ctrl_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12,
  parameter int STEPS  = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              halt,
  input logic              extDone,
  input logic              memRead,
  input logic              memWrite,
  input logic              regRefEn,
  input logic              ioEn,
  input logic [STEPS-1:0]  timeStep,
  input logic [DATA_W-1:0] acOut,
  input logic [ADDR_W-1:0] pcOut
);
  localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pcOut == '0) && (acOut == '0) && timeStep[0]);

  // R2
  step_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot(timeStep));

  // R3
  fetch_advance_chk: assert property (@(posedge clk) disable iff (rst)
    timeStep[1] && !halt |=> pcOut == $past(pcOut) + ONE);

  // R10
  wait_done_chk: assert property (@(posedge clk) disable iff (rst)
    (regRefEn || ioEn) && !extDone |=> timeStep[3]);

  // R10
  done_return_chk: assert property (@(posedge clk) disable iff (rst)
    (regRefEn || ioEn) && extDone |=> timeStep[0]);

  // R11
  halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    halt |-> !memRead && !memWrite && !regRefEn && !ioEn);

  // R11
  halt_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    halt |=> $stable(timeStep) && $stable(pcOut) && $stable(acOut));

  // R12
  rw_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(memRead && memWrite));

  // R12
  write_step_chk: assert property (@(posedge clk) disable iff (rst)
    memWrite |-> timeStep[4] || timeStep[6]);

endmodule

bind instr_cycle_ctrl instr_cycle_ctrl_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .STEPS(STEPS)
) uChk (
  .clk(clk), .rst(rst), .halt(halt), .extDone(extDone),
  .memRead(memRead), .memWrite(memWrite), .regRefEn(regRefEn),
  .ioEn(ioEn), .timeStep(timeStep), .acOut(acOut), .pcOut(pcOut)
);

// File: tb/instr_cycle_ctrl_test.sv
module instr_cycle_ctrl_test;
  logic        clk = 1'b0;
  logic        rst, halt, extDone;
  logic [15:0] memRdData, memWrData, acOut;
  logic [11:0] memAddr, pcOut;
  logic        memRead, memWrite, regRefEn, ioEn;
  logic [6:0]  timeStep;

  logic [15:0] dutMem [0:4095];
  logic [15:0] refMem [0:4095];

  int checks = 0;
  int failures = 0;

  // reference model state
  int          mSc = 0;
  logic [11:0] mPc, mAr;
  logic [15:0] mAc, mDr, mIr;
  logic        mI;
  bit          modelValid = 1'b0;
  int          waitCnt = 0;

  always #10 clk = ~clk;   // 50 MHz

  instr_cycle_ctrl uut (
    .clk(clk), .rst(rst), .halt(halt), .extDone(extDone),
    .memRdData(memRdData), .memAddr(memAddr), .memWrData(memWrData),
    .memRead(memRead), .memWrite(memWrite), .regRefEn(regRefEn),
    .ioEn(ioEn), .timeStep(timeStep), .acOut(acOut), .pcOut(pcOut)
  );

  assign memRdData = dutMem[memAddr];
  always @(posedge clk) if (memWrite) dutMem[memAddr] <= memWrData;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic put(input int a, input logic [15:0] v);
    dutMem[a] = v;
    refMem[a] = v;
  endtask

  function automatic string tagFor();
    logic [2:0] opc = mIr[14:12];
    if (halt) return "R11";
    if (mSc < 3) return "R3";
    if (opc == 3'd7) return "R10";
    if (mSc == 3) return "R4";
    case (opc)
      3'd0, 3'd1, 3'd2: return "R5";
      3'd3: return "R6";
      3'd4: return "R7";
      3'd5: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic compareAll();
    logic [2:0]  opc = mIr[14:12];
    bit          expRd, expWr, expRr, expIo;
    logic [15:0] expWd;
    string       tg = tagFor();
    expRd = !halt && (mSc == 1 || (mSc == 3 && opc != 3'd7 && mI) ||
            (mSc == 4 && (opc == 3'd0 || opc == 3'd1 || opc == 3'd2 || opc == 3'd6)));
    expWr = !halt && ((mSc == 4 && (opc == 3'd3 || opc == 3'd5)) ||
                      (mSc == 6 && opc == 3'd6));
    expRr = !halt && mSc == 3 && opc == 3'd7 && !mI;
    expIo = !halt && mSc == 3 && opc == 3'd7 && mI;
    expWd = (opc == 3'd3) ? mAc : (opc == 3'd5) ? {4'h0, mPc} : mDr;
    chk(timeStep === 7'(1 << mSc), "R2", "timeStep", 32'(timeStep), 32'(1 << mSc));
    chk(pcOut === mPc, tg, "pcOut", 32'(pcOut), 32'(mPc));
    chk(acOut === mAc, tg, "acOut", 32'(acOut), 32'(mAc));
    chk(memAddr === mAr, tg, "memAddr", 32'(memAddr), 32'(mAr));
    chk(memRead === expRd, tg, "memRead", 32'(memRead), 32'(expRd));
    chk(memWrite === expWr, tg, "memWrite", 32'(memWrite), 32'(expWr));
    chk(regRefEn === expRr, "R10", "regRefEn", 32'(regRefEn), 32'(expRr));
    chk(ioEn === expIo, "R10", "ioEn", 32'(ioEn), 32'(expIo));
    chk(!(memRead && memWrite), "R12", "read+write", 32'({memRead, memWrite}), 32'h0);
    if (expWr) chk(memWrData === expWd, tg, "memWrData", 32'(memWrData), 32'(expWd));
  endtask

  task automatic stepModel(input bit ext);
    logic [2:0] opc = mIr[14:12];
    if (rst) begin
      mSc = 0; mPc = '0; mAr = '0; mAc = '0; mDr = '0; mIr = '0; mI = 1'b0;
    end else if (!halt) begin
      case (mSc)
        0: begin mAr = mPc; mSc = 1; end
        1: begin mIr = refMem[mAr]; mPc = mPc + 12'd1; mSc = 2; end
        2: begin mI = mIr[15]; mAr = mIr[11:0]; mSc = 3; end
        3: begin
          if (opc == 3'd7) begin
            if (ext) mSc = 0;
          end else begin
            if (mI) mAr = refMem[mAr][11:0];
            mSc = 4;
          end
        end
        4: begin
          case (opc)
            3'd3: begin refMem[mAr] = mAc; mSc = 0; end
            3'd4: begin mPc = mAr; mSc = 0; end
            3'd5: begin refMem[mAr] = {4'h0, mPc}; mAr = mAr + 12'd1; mSc = 5; end
            default: begin mDr = refMem[mAr]; mSc = 5; end
          endcase
        end
        5: begin
          case (opc)
            3'd0: begin mAc = mAc & mDr; mSc = 0; end
            3'd1: begin mAc = mAc + mDr; mSc = 0; end
            3'd2: begin mAc = mDr; mSc = 0; end
            3'd5: begin mPc = mAr; mSc = 0; end
            default: begin mDr = mDr + 16'd1; mSc = 6; end
          endcase
        end
        default: begin
          refMem[mAr] = mDr;
          if (mDr == 16'd0) mPc = mPc + 12'd1;
          mSc = 0;
        end
      endcase
    end
  endtask

  always @(negedge clk) begin
    bit nextDone = 1'b0;
    if (modelValid && !rst) compareAll();
    if (!rst && !halt && modelValid && mSc == 3 && mIr[14:12] == 3'd7) begin
      if (waitCnt >= (mI ? 0 : 2)) nextDone = 1'b1;
      waitCnt++;
    end else begin
      waitCnt = 0;
    end
    extDone = nextDone;
    stepModel(nextDone);
    if (rst) modelValid = 1'b1;
  end

  initial begin
    #(20 * 100000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst = 1'b1; halt = 1'b0; extDone = 1'b0;
    for (int a = 0; a < 4096; a++) put(a, 16'h0000);
    put(12'h000, 16'h2100);  // load
    put(12'h001, 16'h1101);  // add
    put(12'h002, 16'h8102);  // and, indirect
    put(12'h003, 16'h3104);  // store
    put(12'h004, 16'h7800);  // register-operation handoff
    put(12'h005, 16'hF400);  // i/o handoff
    put(12'h006, 16'h6105);  // increment, skips
    put(12'h007, 16'h0000);  // skipped
    put(12'h008, 16'h6106);  // increment, no skip
    put(12'h009, 16'h5200);  // call
    put(12'h201, 16'hC200);  // indirect branch back
    put(12'h00A, 16'hB107);  // indirect store
    put(12'h00B, 16'h400B);  // branch to self
    put(12'h100, 16'h1234);
    put(12'h101, 16'hF00F);
    put(12'h102, 16'h0103);
    put(12'h103, 16'h00FF);
    put(12'h105, 16'hFFFF);
    put(12'h106, 16'h0005);
    put(12'h107, 16'h0108);

    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    @(negedge clk); #1;
    // R1: reset state
    chk(pcOut === 12'h000, "R1", "pcOut", 32'(pcOut), 32'h0);
    chk(acOut === 16'h0000, "R1", "acOut", 32'(acOut), 32'h0);
    chk(timeStep === 7'b0000001, "R1", "timeStep", 32'(timeStep), 32'h1);
    chk(!memRead && !memWrite, "R1", "strobes", 32'({memRead, memWrite}), 32'h0);

    repeat (40) @(posedge clk);
    #2 halt = 1'b1;            // R11 window
    repeat (4) @(posedge clk);
    #2 halt = 1'b0;
    repeat (150) @(posedge clk);

    @(negedge clk); #1;
    chk(dutMem[12'h104] === 16'h0043, "R6", "M[104]", 32'(dutMem[12'h104]), 32'h43);
    chk(dutMem[12'h105] === 16'h0000, "R9", "M[105]", 32'(dutMem[12'h105]), 32'h0);
    chk(dutMem[12'h106] === 16'h0006, "R9", "M[106]", 32'(dutMem[12'h106]), 32'h6);
    chk(dutMem[12'h200] === 16'h000A, "R8", "M[200]", 32'(dutMem[12'h200]), 32'hA);
    chk(dutMem[12'h108] === 16'h0043, "R4", "M[108]", 32'(dutMem[12'h108]), 32'h43);
    chk(acOut === 16'h0043, "R5", "final acOut", 32'(acOut), 32'h43);
    chk(pcOut === 12'h00B || pcOut === 12'h00C, "R7", "loop pcOut", 32'(pcOut), 32'hB);

    @(posedge clk); #2 rst = 1'b1;
    repeat (2) @(posedge clk);
    #2 rst = 1'b0;
    @(negedge clk); #1;
    chk(pcOut === 12'h000, "R1", "pcOut after rerun reset", 32'(pcOut), 32'h0);
    chk(acOut === 16'h0000, "R1", "acOut after rerun reset", 32'(acOut), 32'h0);
    chk(timeStep === 7'b0000001, "R1", "timeStep after rerun reset", 32'(timeStep), 32'h1);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule